// File: doc/BRIEF.md
# Back-to-Back Conversion Trigger Sequencer

This block chains conversion start requests toward an analog-to-digital converter from a single software start. On a start request it latches the set of enabled channels and fires a pre-trigger on the lowest enabled channel in the next cycle. The following pre-triggers are paced by the converter and not by timers. Each one fires only after the converter acknowledges that the current conversion is complete, and it goes to the next enabled channel in ascending index order.

Only one conversion is outstanding at a time. When the acknowledge for the last enabled channel arrives, the block emits a one-cycle done pulse and returns to idle. The result collector can then start the next scan with a fresh software start. A start request that arrives while a scan is running has no effect on the scan and sets a sticky overrun error flag. The channel count is a parameter, with four channels by default.

Top module: `bb_trig_seq`

## Requirements
- R1: While reset is asserted and right after it, `pretrig_o` is zero, `done_o` is 0, `ovr_err_o` is 0 and `ch_idx_o` is 0.
- R2: When `sw_trig_i` is sampled high while idle, the pre-trigger bit of the lowest enabled channel is high in the very next cycle.
- R3: Every later pre-trigger appears in the cycle after `adc_ack_i` is sampled high. No pre-trigger appears while an acknowledge is awaited.
- R4: `pretrig_o` has at most one bit set and holds each bit for exactly one cycle. Bit k of `pretrig_o` corresponds to `ch_idx_o == k`, and `ch_idx_o` keeps the last issued channel until the next pre-trigger.
- R5: Channels whose `ch_en_i` bit is 0 are skipped. The next enabled channel above the current one is triggered on the same acknowledge, so channels are issued in strictly ascending index order.
- R6: The enable mask is captured when the scan starts. Changes on `ch_en_i` during a scan do not alter that scan.
- R7: In the cycle after the acknowledge of the last enabled channel, `done_o` is high for exactly one cycle with `pretrig_o` zero. A start request sampled in that same cycle begins a new scan.
- R8: A start request with an all-zero enable mask produces a done pulse in the next cycle and no pre-trigger.
- R9: A start request sampled while a scan is running leaves the scan unchanged and sets `ovr_err_o`. The flag stays set until reset.
- R10: An acknowledge sampled while idle produces neither a pre-trigger nor a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_trig_i | input | 1 | Software start request, sampled each cycle |
| ch_en_i | input | NUM_CH | Per-channel enable, captured at scan start |
| adc_ack_i | input | 1 | Converter completion acknowledge |
| pretrig_o | output | NUM_CH | One-cycle pre-trigger pulse per channel |
| ch_idx_o | output | $clog2(NUM_CH) | Index of the last issued channel |
| done_o | output | 1 | One-cycle scan-complete pulse |
| ovr_err_o | output | 1 | Sticky overrun: start request while busy |

## Verification
The assertions check on every cycle the structural properties of the pre-trigger vector: at most one bit set, no bit held for two cycles, agreement with the channel index, and no second pre-trigger or done pulse while a conversion is still unacknowledged. They also check that the done pulse never coincides with a pre-trigger and that the overrun flag never clears. The order in which channels are visited is shown only by the bench scenarios, which drive random masks and random converter latencies. The bench scenarios also cover the capture of the enable mask at the start, the exact cycle of each pulse, the empty mask case, a restart in the done cycle, and rejection of start requests while busy.

// File: rtl/bbts_pkg.sv
package bbts_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bbts_pick.sv
// Lowest set bit of mask_i at or above start_i.
module bbts_pick #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [IDX_W:0]    start_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(start_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bbts_onehot.sv
module bbts_onehot #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NUM_CH-1:0] vec_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_bit
    assign vec_o[k] = en_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/bbts_ctrl.sv
module bbts_ctrl
  import bbts_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_trig_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              adc_ack_i,
  output logic              fire_o,
  output logic [IDX_W-1:0]  cur_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e          state_q, state_d;
  logic [NUM_CH-1:0]   mask_q, mask_d;
  logic [IDX_W-1:0]    cur_q, cur_d;
  logic                fire_q, fire_d;
  logic                done_q, done_d;
  logic                err_q, err_d;

  logic [NUM_CH-1:0]   sel_mask;
  logic [IDX_W:0]      sel_start;
  logic                sel_found;
  logic [IDX_W-1:0]    sel_idx;
  logic                go, step;

  assign go        = (state_q == ST_IDLE) && sw_trig_i;
  assign step      = (state_q == ST_WAIT) && adc_ack_i;
  assign sel_mask  = (state_q == ST_IDLE) ? ch_en_i : mask_q;
  assign sel_start = (state_q == ST_IDLE) ? '0 : ({1'b0, cur_q} + 1'b1);

  bbts_pick #(.NUM_CH(NUM_CH)) pick_i (
    .mask_i  (sel_mask),
    .start_i (sel_start),
    .found_o (sel_found),
    .idx_o   (sel_idx)
  );

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    cur_d   = cur_q;
    fire_d  = 1'b0;
    done_d  = 1'b0;
    err_d   = err_q | ((state_q == ST_WAIT) && sw_trig_i);
    if (go) mask_d = ch_en_i;
    if (go || step) begin
      if (sel_found) begin
        fire_d  = 1'b1;
        cur_d   = sel_idx;
        state_d = ST_WAIT;
      end else begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      cur_q   <= '0;
      fire_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      cur_q   <= cur_d;
      fire_q  <= fire_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign fire_o = fire_q;
  assign cur_o  = cur_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/bb_trig_seq.sv
module bb_trig_seq #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_trig_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              adc_ack_i,
  output logic [NUM_CH-1:0] pretrig_o,
  output logic [IDX_W-1:0]  ch_idx_o,
  output logic              done_o,
  output logic              ovr_err_o
);
  logic fire;

  bbts_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_trig_i (sw_trig_i),
    .ch_en_i   (ch_en_i),
    .adc_ack_i (adc_ack_i),
    .fire_o    (fire),
    .cur_o     (ch_idx_o),
    .done_o    (done_o),
    .err_o     (ovr_err_o)
  );

  bbts_onehot #(.NUM_CH(NUM_CH)) dec_i (
    .en_i  (fire),
    .idx_i (ch_idx_o),
    .vec_o (pretrig_o)
  );
endmodule

// File: rtl/bbts_chk.sv
module bbts_chk #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_ack_i,
  input logic [NUM_CH-1:0] pretrig_o,
  input logic [IDX_W-1:0]  ch_idx_o,
  input logic              done_o,
  input logic              ovr_err_o
);
  // a conversion has been triggered and not yet acknowledged
  logic outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else         outst_q <= ((pretrig_o != '0) || outst_q) && !adc_ack_i;
  end

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pretrig_o));

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pretrig_o != '0) |=> ((pretrig_o & $past(pretrig_o)) == '0));

  a_r4_idx_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pretrig_o != '0) |-> pretrig_o[ch_idx_o]);

  a_r3_wait_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pretrig_o != '0) |-> !outst_q);

  a_r7_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!outst_q && (pretrig_o == '0)));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o |=> ovr_err_o);
endmodule

bind bb_trig_seq bbts_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adc_ack_i (adc_ack_i),
  .pretrig_o (pretrig_o),
  .ch_idx_o  (ch_idx_o),
  .done_o    (done_o),
  .ovr_err_o (ovr_err_o)
);

// File: tb/bb_trig_seq_tb_top.sv
module bb_trig_seq_tb_top;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned IDX_W  = $clog2(NUM_CH);
  localparam time         CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sw_trig_i = 1'b0;
  logic [NUM_CH-1:0] ch_en_i = '0;
  logic              adc_ack_i = 1'b0;
  logic [NUM_CH-1:0] pretrig_o;
  logic [IDX_W-1:0]  ch_idx_o;
  logic              done_o;
  logic              ovr_err_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bb_trig_seq #(.NUM_CH(NUM_CH)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_trig_i (sw_trig_i),
    .ch_en_i   (ch_en_i),
    .adc_ack_i (adc_ack_i),
    .pretrig_o (pretrig_o),
    .ch_idx_o  (ch_idx_o),
    .done_o    (done_o),
    .ovr_err_o (ovr_err_o)
  );

  // lowest enabled channel at or above 'from', -1 if none
  function automatic int exp_next(input logic [NUM_CH-1:0] m, input int from);
    for (int i = from; i < int'(NUM_CH); i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // pre: start request already driven for the coming edge
  // chain: leave a new start request asserted in the done cycle
  task automatic scan(input logic [NUM_CH-1:0] m, input bit poke, input bit pre,
                      input bit chain, input logic [NUM_CH-1:0] next_m);
    int c;
    bit first = 1'b1;
    if (!pre) begin
      @(negedge clk_i);
      sw_trig_i = 1'b1;
      ch_en_i   = m;
    end
    @(negedge clk_i);
    sw_trig_i = 1'b0;
    ch_en_i   = NUM_CH'($urandom);  // R6: mid-scan mask change must not matter
    c = exp_next(m, 0);
    if (c < 0) begin
      chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
      chk(pretrig_o == '0, "R8 no pretrig", int'(pretrig_o), 0);
    end
    while (c >= 0) begin
      chk(pretrig_o == NUM_CH'(1 << c), first ? "R2 first pretrig" : "R3/R5 next pretrig",
          int'(pretrig_o), 1 << c);
      chk(ch_idx_o == IDX_W'(c), "R4 idx", int'(ch_idx_o), c);
      chk(done_o == 1'b0, "R7 no early done", int'(done_o), 0);
      first = 1'b0;
      for (int j = 0; j < int'(1 + $urandom % 6); j++) begin
        sw_trig_i = poke && (j == 0);
        @(negedge clk_i);
        sw_trig_i = 1'b0;
        chk(pretrig_o == '0, "R3/R9 no pretrig while waiting", int'(pretrig_o), 0);
        chk(ch_idx_o == IDX_W'(c), "R4 idx held", int'(ch_idx_o), c);
      end
      adc_ack_i = 1'b1;
      @(negedge clk_i);
      adc_ack_i = 1'b0;
      c = exp_next(m, c + 1);
      if (c < 0) begin
        chk(done_o == 1'b1, "R7 done after last ack", int'(done_o), 1);
        chk(pretrig_o == '0, "R7 no pretrig with done", int'(pretrig_o), 0);
      end
    end
    if (poke) chk(ovr_err_o == 1'b1, "R9 overrun flag", int'(ovr_err_o), 1);
    if (chain) begin
      sw_trig_i = 1'b1;
      ch_en_i   = next_m;
    end else begin
      @(negedge clk_i);
      chk(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
      chk(pretrig_o == '0, "R7 idle after done", int'(pretrig_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk_i);
    chk(pretrig_o == '0, "R1 pretrig", int'(pretrig_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(ovr_err_o == 1'b0, "R1 err", int'(ovr_err_o), 0);
    chk(ch_idx_o == '0, "R1 idx", int'(ch_idx_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pretrig_o == '0 && done_o == 1'b0, "R1 after release", int'(pretrig_o), 0);

    // R10: acknowledge while idle
    adc_ack_i = 1'b1;
    @(negedge clk_i);
    adc_ack_i = 1'b0;
    chk(pretrig_o == '0, "R10 no pretrig", int'(pretrig_o), 0);
    chk(done_o == 1'b0, "R10 no done", int'(done_o), 0);
    @(negedge clk_i);
    chk(pretrig_o == '0 && done_o == 1'b0, "R10 still idle", int'(pretrig_o), 0);

    scan(4'hF, 1'b0, 1'b0, 1'b0, '0);
    scan(4'h0, 1'b0, 1'b0, 1'b0, '0);   // R8
    scan(4'h8, 1'b0, 1'b0, 1'b0, '0);   // R5 skip to top channel
    scan(4'h5, 1'b0, 1'b0, 1'b0, '0);   // R5 gaps
    chk(ovr_err_o == 1'b0, "R9 no spurious overrun", int'(ovr_err_o), 0);
    scan(4'h3, 1'b0, 1'b0, 1'b1, 4'h6); // R7 restart in done cycle
    scan(4'h6, 1'b0, 1'b1, 1'b0, '0);
    scan(4'hA, 1'b1, 1'b0, 1'b0, '0);   // R9 overrun during scan
    scan(4'h9, 1'b0, 1'b0, 1'b0, '0);
    chk(ovr_err_o == 1'b1, "R9 flag sticky", int'(ovr_err_o), 1);

    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(ovr_err_o == 1'b0, "R1 R9 flag cleared by reset", int'(ovr_err_o), 0);
    rst_ni = 1'b1;

    for (int n = 0; n < 40; n++) begin
      scan(NUM_CH'($urandom), ($urandom % 5) == 0, 1'b0, 1'b0, '0);
    end
    summary();
  end
endmodule